// File: doc/BRIEF.md
# SPI Master/Slave Controller

This block is a full-duplex serial peripheral interface controller built around one 8-bit shift register. The same register serves both roles. As a master, the block makes the serial clock from the core clock through a divider picked by two rate bits. As a slave, it follows an external clock and an active-low select. The register file holds a control register, a status register and a data register. Clock polarity, clock phase and bit order can each be set by software.

Writing the data register starts a byte. As a master the block clocks the byte out. As a slave it preloads the byte it will return. The received byte can be read back from the same address when the transfer completes. Select can be honoured or ignored. When it is honoured, a select-low event seen while the block is an enabled master forces it back to slave and records a mode fault.

Register map: address 0 is control, address 1 is status, address 2 is data. Control bits: bit 0 enable, bit 1 master, bit 2 clock idle level (polarity), bit 3 phase, bit 4 LSB-first, bit 5 select-ignore, bits 7:6 rate. Status bits: bit 0 transfer complete, bit 1 write collision, bit 2 mode fault. Each status bit is cleared by writing 1 to it.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, the control, status and data registers read 0 and all three output enables (sclk_oe_o, mosi_oe_o, miso_oe_o) are low.
- R2: In master mode, the rate field values 0, 1, 2 and 3 give serial clock half periods of 2, 8, 32 and 64 core cycles. A byte has exactly 16 clock edges. When no transfer is running, sclk_o sits at the control bit 2 level.
- R3: With phase 0, data is sampled on the leading edge and shifted out on the trailing edge, and the first bit is present before the first edge. With phase 1, data is shifted out on the leading edge and sampled on the trailing edge. A leading edge is the edge that leaves the idle level.
- R4: When control bit 4 is 0, bit 7 moves first. When it is 1, bit 0 moves first. This holds for both the transmitted and the received byte.
- R5: Status bit 0 sets once eight bits have been sampled, and the data register then reads the received byte. Writing 1 to a status bit clears it.
- R6: Writing the data register while a transfer is running sets status bit 1 and leaves the transfer and its data unchanged.
- R7: An enabled master drives sclk_o and mosi_o (oe high) while a transfer runs. When it is idle, it drives them only if select-ignore is 1.
- R8: When select-ignore is 0 and ss_ni goes low while the block is an enabled master, the block clears control bit 1, sets status bit 2, and releases sclk and mosi. Because it is now a selected slave, it drives miso.
- R9: When select-ignore is 1, ss_ni has no effect. A master never takes a mode fault, and a slave (control bit 1 = 0) is always selected.
- R10: An enabled slave shifts on the external clock in the configured mode only while it is selected. It drives miso_o only while it is selected, and it sets status bit 0 after eight sampled bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| sclk_i | input | 1 | Serial clock from the bus (slave role) |
| sclk_o | output | 1 | Serial clock to the bus (master role) |
| sclk_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line as seen by a slave |
| mosi_o | output | 1 | Master-out data driven by this block |
| mosi_oe_o | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line as seen by a master |
| miso_o | output | 1 | Slave-out data driven by this block |
| miso_oe_o | output | 1 | Slave-out output enable |
| ss_ni | input | 1 | Active-low slave select |

## Verification
The bench uses the default parameters: an 8-bit shift length and a 6-bit divider counter. With these values every rate setting can be run, including the 64-cycle half period, and a full byte takes at most about a thousand cycles. Each master vector drives a bench slave model that reacts to sclk_o edges in all four polarity/phase combinations and in both bit orders. The slave runs use a slow bench clock, which exercises the synchronised input path, and the select-fault and select-ignore cases are run directly.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    logic       sel_ign;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic       mstr;
    logic       en;
  } ctrl_t;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       modf;
    logic       wcol;
    logic       done;
  } stat_t;

  // half period minus one, in core cycles, for core/4, /16, /64, /128
  function automatic int unsigned half_m1(input logic [1:0] rate);
    case (rate)
      2'd0:    return 1;
      2'd1:    return 7;
      2'd2:    return 31;
      default: return 63;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[i]}};
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R2
  div_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> !tick_o);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clear_i,
  input  logic              lsb_first_i,
  input  logic              cpha_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              rx_bit_i,
  output logic              tx_bit_o,
  output logic              done_o,
  output logic              active_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int unsigned CW = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q, sr_nx;
  logic [CW-1:0]     cnt_q;
  logic              tx_q, out_sel, sample, drive, last;

  assign out_sel = lsb_first_i ? sr_q[0] : sr_q[DATA_W-1];
  assign sample  = cpha_i ? trail_i : lead_i;
  assign drive   = cpha_i ? lead_i  : trail_i;
  assign sr_nx   = lsb_first_i ? {rx_bit_i, sr_q[DATA_W-1:1]}
                               : {sr_q[DATA_W-2:0], rx_bit_i};
  assign last    = (cnt_q == CW'(DATA_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else if (load_i) begin
      sr_q  <= load_data_i;
      cnt_q <= '0;
      tx_q  <= lsb_first_i ? load_data_i[0] : load_data_i[DATA_W-1];
    end else begin
      if (sample) sr_q <= sr_nx;
      if (clear_i)     cnt_q <= '0;
      else if (sample) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (drive) tx_q <= out_sel;
      // phase 0: first bit sits on the line before any edge
      else if (!cpha_i && cnt_q == '0 && !sample) tx_q <= out_sel;
    end
  end

  assign done_o    = sample && !clear_i && last;
  assign active_o  = (cnt_q != '0);
  assign tx_bit_o  = tx_q;
  assign rx_word_o = sr_nx;
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  input  logic             ss_ni
);
  localparam int unsigned EW = $clog2(2*DATA_W);

  ctrl_t             ctrl_q;
  stat_t             stat_q;
  logic [DATA_W-1:0] rx_q;

  // slave-side inputs cross into the core clock
  logic sclk_s, mosi_s, ss_s;
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, mosi_i, sclk_i}),
    .q_o    ({ss_s, mosi_s, sclk_s})
  );

  logic master, ss_low, slave_sel, modf_evt;
  assign master    = ctrl_q.en & ctrl_q.mstr;
  assign ss_low    = !ss_s;
  assign slave_sel = ctrl_q.en & !ctrl_q.mstr & (ctrl_q.sel_ign | ss_low);
  assign modf_evt  = master & !ctrl_q.sel_ign & ss_low;

  logic wr_ctrl, wr_stat, wr_data;
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign wr_data = wr_en_i && (wr_addr_i == ADDR_DATA);

  logic             m_busy_q, sclk_q, tick, s_active, busy, load, m_start, wcol_evt;
  logic [EW-1:0]    edge_q;
  logic [CNT_W-1:0] half_m1_w;

  assign busy     = master ? m_busy_q : s_active;
  assign wcol_evt = wr_data & busy;
  assign load     = wr_data & !busy & !modf_evt;
  assign m_start  = load & master;
  assign half_m1_w = CNT_W'(half_m1(ctrl_q.rate));

  spi_clk_div #(.CNT_W(CNT_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (m_busy_q),
    .half_m1_i (half_m1_w),
    .tick_o    (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy_q <= 1'b0;
      edge_q   <= '0;
      sclk_q   <= 1'b0;
    end else if (modf_evt || !master) begin
      m_busy_q <= 1'b0;
      edge_q   <= '0;
    end else if (m_start) begin
      m_busy_q <= 1'b1;
      edge_q   <= '0;
      sclk_q   <= ctrl_q.cpol;
    end else if (tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= edge_q + 1'b1;
      if (edge_q == EW'(2*DATA_W-1)) m_busy_q <= 1'b0;
    end
  end

  logic m_lead, m_trail, s_prev_q, s_lead, s_trail;
  assign m_lead  = tick & (sclk_q == ctrl_q.cpol);
  assign m_trail = tick & (sclk_q != ctrl_q.cpol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_prev_q <= 1'b0;
    else         s_prev_q <= sclk_s;
  end

  assign s_lead  = slave_sel & (s_prev_q == ctrl_q.cpol) & (sclk_s != ctrl_q.cpol);
  assign s_trail = slave_sel & (s_prev_q != ctrl_q.cpol) & (sclk_s == ctrl_q.cpol);

  logic              tx_bit, done;
  logic [DATA_W-1:0] rx_word;

  spi_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (DATA_W'(wr_data_i)),
    .clear_i     (modf_evt | (!master & !slave_sel)),
    .lsb_first_i (ctrl_q.lsb_first),
    .cpha_i      (ctrl_q.cpha),
    .lead_i      (master ? m_lead  : s_lead),
    .trail_i     (master ? m_trail : s_trail),
    .rx_bit_i    (master ? miso_i  : mosi_s),
    .tx_bit_o    (tx_bit),
    .done_o      (done),
    .active_o    (s_active),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= ctrl_t'(wr_data_i);
      if (modf_evt) ctrl_q.mstr <= 1'b0;
      if (wr_stat) begin
        if (wr_data_i[0]) stat_q.done <= 1'b0;
        if (wr_data_i[1]) stat_q.wcol <= 1'b0;
        if (wr_data_i[2]) stat_q.modf <= 1'b0;
      end
      if (done)     stat_q.done <= 1'b1;
      if (wcol_evt) stat_q.wcol <= 1'b1;
      if (modf_evt) stat_q.modf <= 1'b1;
      if (done)     rx_q <= rx_word;
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_CTRL: rd_data_o = ctrl_q;
      ADDR_STAT: rd_data_o = stat_q;
      ADDR_DATA: rd_data_o = REG_W'(rx_q);
      default:   rd_data_o = '0;
    endcase
  end

  assign sclk_o    = m_busy_q ? sclk_q : ctrl_q.cpol;
  assign sclk_oe_o = master & (m_busy_q | ctrl_q.sel_ign);
  assign mosi_oe_o = sclk_oe_o;
  assign mosi_o    = tx_bit;
  assign miso_o    = tx_bit;
  assign miso_oe_o = slave_sel;

  // R6
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && busy) |=> stat_q.wcol);
  // R8
  modf_role_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.modf) |-> !ctrl_q.mstr);
  // R9
  ign_no_modf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.modf) |-> !$past(ctrl_q.sel_ign));
  // R7
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_oe_o |-> !miso_oe_o);
endmodule

// File: tb/test_spi_xcvr.sv
module test_spi_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {control, byte sent by the block, byte returned by the bench slave}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h03_A5_3C, 24'h4B_81_7E, 24'h17_1F_C3,
    24'hBF_6D_92, 24'hE7_F0_0F, 24'h1B_00_FF
  };
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_ni = 1'b1;
  logic       sclk_o, sclk_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;
  int         n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xcvr i_spi_xcvr (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .ss_ni(ss_ni)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  function automatic logic bitof(input logic [7:0] v, input int i, input logic lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  function automatic int half(input logic [1:0] r);
    case (r) 2'd0: return 2; 2'd1: return 8; 2'd2: return 32; default: return 64; endcase
  endfunction

  task automatic do_master(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] mi, input bit collide);
    logic cpol, cpha, lsb, ign, prev, lead;
    logic [7:0] got, v;
    int n_edge, drv, smp, t1, t2, cyc;
    cpol = c[2]; cpha = c[3]; lsb = c[4]; ign = c[5];
    got = '0; n_edge = 0; smp = 0; t1 = 0; t2 = 0; cyc = 0;
    wr(A_STAT, 8'h07);
    wr(A_CTRL, c);
    chk("R2", "idle sclk level", 32'(sclk_o), 32'(cpol));
    chk("R7", "idle sclk_oe", 32'(sclk_oe_o), 32'(ign));
    miso_i = bitof(mi, 0, lsb);
    drv = cpha ? 0 : 1;
    wr(A_DATA, tx);
    prev = cpol;
    while (n_edge < 16 && cyc < 5000) begin
      @(negedge clk); cyc++;
      wr_en = 1'b0;
      if (sclk_o !== prev) begin
        lead = (prev == cpol); prev = sclk_o; n_edge++;
        if (n_edge == 1) begin
          t1 = cyc;
          chk("R7", "busy mosi_oe", 32'(mosi_oe_o), 32'd1);
        end
        if (n_edge == 2) t2 = cyc;
        if (lead ^ cpha) begin
          got[lsb ? smp : 7-smp] = mosi_o; smp++;
        end else begin
          if (drv < 8) miso_i = bitof(mi, drv, lsb);
          drv++;
        end
        if (collide && n_edge == 4) begin
          wr_en = 1'b1; wr_addr = A_DATA; wr_data = 8'hFF;
        end
      end
    end
    chk("R2", "edge count", 32'(n_edge), 32'd16);
    chk("R2", "half period", 32'(t2 - t1), 32'(half(c[7:6])));
    repeat (4) @(negedge clk);
    chk("R2", "sclk back to idle", 32'(sclk_o), 32'(cpol));
    rd(A_STAT, v);
    chk(collide ? "R6" : "R5", "status", 32'(v), collide ? 32'h3 : 32'h1);
    rd(A_DATA, v);
    chk("R3 R4 R5", "master rx byte", 32'(v), 32'(mi));
    chk("R3 R4", "master mosi bits", 32'(got), 32'(tx));
  endtask

  task automatic do_slave(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] mi);
    localparam int H = 8;
    logic cpol, cpha, lsb;
    logic [7:0] got, v;
    cpol = c[2]; cpha = c[3]; lsb = c[4]; got = '0;
    sclk_i = cpol; mosi_i = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_STAT, 8'h07);
    wr(A_CTRL, c);
    wr(A_DATA, tx);
    ss_ni = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10", "selected miso_oe", 32'(miso_oe_o), 32'd1);
    for (int k = 0; k < 8; k++) begin
      if (!cpha) begin
        mosi_i = bitof(mi, k, lsb);
        repeat (H) @(negedge clk);
        sclk_i = ~cpol; got[lsb ? k : 7-k] = miso_o;
        repeat (H) @(negedge clk);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol; mosi_i = bitof(mi, k, lsb);
        repeat (H) @(negedge clk);
        sclk_i = cpol; got[lsb ? k : 7-k] = miso_o;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    rd(A_STAT, v);
    chk("R10 R5", "slave done", 32'(v), 32'h1);
    rd(A_DATA, v);
    chk("R10 R3 R4", "slave rx byte", 32'(v), 32'(mi));
    chk("R10 R3 R4", "slave miso bits", 32'(got), 32'(tx));
    ss_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(c[5] ? "R9" : "R10", "miso_oe after deselect", 32'(miso_oe_o), 32'(c[5]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (R1..all) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(A_CTRL, v); chk("R1", "ctrl after reset", 32'(v), 32'h0);
    rd(A_STAT, v); chk("R1", "stat after reset", 32'(v), 32'h0);
    rd(A_DATA, v); chk("R1", "data after reset", 32'(v), 32'h0);
    chk("R1", "oe after reset", 32'({sclk_oe_o, mosi_oe_o, miso_oe_o}), 32'h0);

    for (int i = 0; i < NVEC; i++)
      do_master(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R6: collision mid-byte
    do_master(8'h03, 8'hC5, 8'h5A, 1'b1);
    // R5: W1C of done and wcol
    wr(A_STAT, 8'h03);
    rd(A_STAT, v); chk("R5", "w1c status", 32'(v), 32'h0);

    do_slave(8'h01, 8'h5A, 8'hC6);
    do_slave(8'h1D, 8'h96, 8'h2B);
    do_slave(8'h25, 8'hE1, 8'h3D);

    // R10: enabled slave not selected
    wr(A_CTRL, 8'h01);
    repeat (4) @(negedge clk);
    chk("R10", "unselected miso_oe", 32'(miso_oe_o), 32'd0);
    // R9: ignore-select slave always selected
    wr(A_CTRL, 8'h21);
    repeat (4) @(negedge clk);
    chk("R9", "ignore slave miso_oe", 32'(miso_oe_o), 32'd1);

    // R8: mode fault
    wr(A_STAT, 8'h07);
    wr(A_CTRL, 8'h03);
    ss_ni = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CTRL, v); chk("R8", "ctrl after fault", 32'(v), 32'h01);
    rd(A_STAT, v); chk("R8", "modf flag", 32'(v), 32'h4);
    chk("R8", "sclk_oe after fault", 32'(sclk_oe_o), 32'd0);
    chk("R8", "miso_oe after fault", 32'(miso_oe_o), 32'd1);
    wr(A_STAT, 8'h04);
    rd(A_STAT, v); chk("R5 R8", "modf cleared", 32'(v), 32'h0);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R9: ignore-select master keeps its role
    wr(A_CTRL, 8'h23);
    ss_ni = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CTRL, v); chk("R9", "ctrl kept", 32'(v), 32'h23);
    rd(A_STAT, v); chk("R9", "no modf", 32'(v), 32'h0);
    chk("R9", "sclk_oe kept", 32'(sclk_oe_o), 32'd1);
    ss_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule